// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that a processor drives through a small 32-bit register bus. Software sets the mode in a control register and writes bytes into a transmit port backed by a 16-entry FIFO. The block shifts each byte out on `sclk`/`mosi` and captures the byte returned on `miso`. Captured bytes go into a 16-entry receive FIFO, where software reads them from a receive port. Status, FIFO occupancy, an active-low chip-select register and a soft-reset register complete the map. All four clock polarity/phase modes, least-significant-bit-first order and an internal loopback path are supported.

A master-inhibit bit lets software queue several bytes before any clock edge appears on the wire. Shifting begins only once that bit is cleared and both the enable and master bits are set. Chip selects follow the select register directly, so software frames each transaction itself. Writing a fixed key to the reset register returns the whole block to its power-up state.

Top module: `spi_reg_master`

## Requirements
- R1: Register byte offsets are fixed as follows. 0x40 is the soft reset. 0x60 is the control register. 0x64 is status. 0x68 is the transmit port and 0x6C the receive port. 0x70 is chip select. 0x74 and 0x78 are the transmit and receive occupancy registers. Control bits are: 0 loopback, 1 enable, 2 master, 3 clock polarity, 4 clock phase, 5 transmit FIFO clear, 6 receive FIFO clear, 7 manual select, 8 master inhibit, 9 LSB first. Control resets to 0x180 and reads back its stored bits in 9:0.
- R2: Status bits are: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full. Bits 4 and 5 read 0. After reset the status reads 0x05.
- R3: A byte written while master inhibit is set, or while enable or master is clear, stays queued and is not shifted. Shifting starts once inhibit is 0 and enable and master are both 1.
- R4: The chip-select register drives `ss_n` directly, one active-low bit per device, and resets to all ones.
- R5: Writing exactly 0x0000000A to offset 0x40 returns control, chip select and both FIFOs to their reset state. Any other value written there has no effect.
- R6: Only bits 7:0 of a transmit write are sent. A receive read returns the byte in bits 7:0, with bits 31:8 at 0.
- R7: Every byte shifted out places exactly one received byte in the receive FIFO. Status bit 2 rises only after the last queued byte has been fully shifted.
- R8: Each occupancy register reads the entry count minus one, and reads 0 when its FIFO is empty.
- R9: With loopback set, the receive path captures `mosi` and ignores `miso`. With loopback clear, `miso` is captured.
- R10: `sclk` idles at the polarity bit. Each half period lasts HALF_DIV system clocks. With phase 0, data is sampled on the first edge of each bit; with phase 1, on the second edge.
- R11: With LSB first clear, bit 7 goes out first. With it set, bit 0 goes out first, and received bits are assembled in the same order.
- R12: A write to a full transmit FIFO is dropped. A read of an empty receive FIFO returns 0 and changes nothing.
- R13: Writing 1 to control bit 5 or bit 6 empties the transmit or receive FIFO, and that bit always reads back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops the receive FIFO at 0x6C |
| rdata | output | 32 | Read data, combinational from addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NCS | Active-low chip selects |

## Verification
Register writes take effect at the edge that samples the strobe, so the bench reads them back on the following cycle. Read data is combinational, so the bench samples it one time step after driving the address at the falling edge. A byte occupies 16·HALF_DIV cycles on the wire, plus one cycle to start it. Rather than counting those cycles exactly, the bench polls the transmit-empty status bit under a cycle bound and only then checks the receive port and the captured `mosi` bits. The `mosi` bits are captured on the sampling edge of the active mode, and the period between consecutive rising `sclk` edges is measured in time and compared with 2·HALF_DIV clocks.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int OFF_SRST = 'h40;
    localparam int OFF_CTRL = 'h60;
    localparam int OFF_STAT = 'h64;
    localparam int OFF_TXD  = 'h68;
    localparam int OFF_RXD  = 'h6C;
    localparam int OFF_SEL  = 'h70;
    localparam int OFF_TXOC = 'h74;
    localparam int OFF_RXOC = 'h78;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    // control fields, bit 0 (loop) at the bottom
    typedef struct packed {
        logic lsb;
        logic inhibit;
        logic manual;
        logic rxclr;
        logic txclr;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loop;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(10'h180);
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = din;
                d.wp = (q.wp == PW'(DEPTH-1)) ? '0 : PW'(q.wp + 1'b1);
            end
            if (do_pop)
                d.rp = (q.rp == PW'(DEPTH-1)) ? '0 : PW'(q.rp + 1'b1);
            if (do_push && !do_pop)
                d.cnt = CW'(q.cnt + 1'b1);
            else if (do_pop && !do_push)
                d.cnt = CW'(q.cnt - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.mem[q.rp];
    assign cnt   = q.cnt;
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (cnt == $past(cnt)));

    // R12
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       lsb,
    input  logic       loop,
    input  logic       miso,
    output logic       take,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    output logic       busy,
    output logic       sclk,
    output logic       mosi
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [3:0]    edg;
        logic [DW-1:0] div;
        logic [7:0]    txsh;
        logic [7:0]    rxsh;
    } eng_t;

    eng_t q, d;
    logic lead, smp, sin, shf;

    assign mosi = lsb ? q.txsh[0] : q.txsh[7];

    always_comb begin
        d       = q;
        take    = 1'b0;
        rx_push = 1'b0;
        sin     = loop ? mosi : miso;
        lead    = ~q.edg[0];
        smp     = cpha ? ~lead : lead;
        shf     = cpha ? (lead && q.edg != 4'd0) : (!lead && q.edg != 4'd15);
        if (abort) begin
            d      = '0;
            d.sclk = cpol;
        end else if (!q.busy) begin
            d.sclk = cpol;
            if (go) begin
                d.busy = 1'b1;
                take   = 1'b1;
                d.txsh = tx_byte;
                d.div  = '0;
                d.edg  = '0;
            end
        end else if (q.div == DW'(HALF_DIV-1)) begin
            d.div  = '0;
            d.sclk = ~q.sclk;
            d.edg  = q.edg + 4'd1;
            if (smp)
                d.rxsh = lsb ? {sin, q.rxsh[7:1]} : {q.rxsh[6:0], sin};
            if (shf)
                d.txsh = lsb ? (q.txsh >> 1) : (q.txsh << 1);
            if (q.edg == 4'd15) begin
                d.busy  = 1'b0;
                rx_push = 1'b1;
            end
        end else begin
            d.div = DW'(q.div + 1'b1);
        end
        rx_byte = d.rxsh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign sclk = q.sclk;

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int NCS      = 4,
    parameter int DEPTH    = 16,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    ss_n
);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        ctrl_t          ctrl;
        logic [NCS-1:0] sel;
    } top_t;

    top_t q, d;

    logic          sw_rst, tx_clr, rx_clr, tx_push, rx_pop, go;
    logic          take, eng_push, eng_busy;
    logic [7:0]    tx_dout, rx_din, rx_dout;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    ctrl_t         wctrl;

    assign wctrl = ctrl_t'(wdata[9:0]);

    always_comb begin
        d       = q;
        sw_rst  = wr_en && (addr == ADDR_W'(OFF_SRST)) && (wdata == SRST_KEY);
        tx_clr  = sw_rst || (wr_en && addr == ADDR_W'(OFF_CTRL) && wctrl.txclr);
        rx_clr  = sw_rst || (wr_en && addr == ADDR_W'(OFF_CTRL) && wctrl.rxclr);
        tx_push = wr_en && (addr == ADDR_W'(OFF_TXD));
        rx_pop  = rd_en && (addr == ADDR_W'(OFF_RXD));
        if (wr_en && addr == ADDR_W'(OFF_CTRL)) begin
            d.ctrl       = wctrl;
            d.ctrl.txclr = 1'b0;
            d.ctrl.rxclr = 1'b0;
        end
        if (wr_en && addr == ADDR_W'(OFF_SEL))
            d.sel = wdata[NCS-1:0];
        if (sw_rst) begin
            d.ctrl = CTRL_RST;
            d.sel  = '1;
        end
        go = q.ctrl.enable && q.ctrl.master && !q.ctrl.inhibit && !tx_empty && !tx_clr;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_CTRL): rdata = {22'b0, q.ctrl};
            ADDR_W'(OFF_STAT): rdata = {28'b0, tx_full, tx_empty && !eng_busy, rx_full, rx_empty};
            ADDR_W'(OFF_RXD):  rdata = rx_empty ? '0 : {24'b0, rx_dout};
            ADDR_W'(OFF_SEL):  rdata = {{(32-NCS){1'b1}}, q.sel};
            ADDR_W'(OFF_TXOC): rdata = tx_empty ? '0 : {{(32-CW){1'b0}}, CW'(tx_cnt - 1'b1)};
            ADDR_W'(OFF_RXOC): rdata = rx_empty ? '0 : {{(32-CW){1'b0}}, CW'(rx_cnt - 1'b1)};
            default:           rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl <= CTRL_RST;
            q.sel  <= '1;
        end else begin
            q <= d;
        end
    end

    byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(wdata[7:0]),
        .pop(take), .dout(tx_dout), .cnt(tx_cnt), .full(tx_full), .empty(tx_empty));

    byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(eng_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .cnt(rx_cnt), .full(rx_full), .empty(rx_empty));

    spi_shift_eng #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(sw_rst), .go(go), .tx_byte(tx_dout),
        .cpol(q.ctrl.cpol), .cpha(q.ctrl.cpha), .lsb(q.ctrl.lsb), .loop(q.ctrl.loop),
        .miso(miso), .take(take), .rx_push(eng_push), .rx_byte(rx_din),
        .busy(eng_busy), .sclk(sclk), .mosi(mosi));

    assign ss_n = q.sel;

    // R3
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.inhibit && !eng_busy) |=> !eng_busy);

    // R5
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ss_n == '1 && q.ctrl == CTRL_RST && rx_empty && tx_empty));

    // R7
    one_rx_per_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(eng_busy) && $past(!sw_rst && !rx_clr && !rx_pop && !rx_full))
        |-> (rx_cnt == CW'($past(rx_cnt) + 1'b1)));
endmodule

// File: tb/spi_reg_master_tb.sv
module spi_reg_master_tb;
    localparam int HALF = 2;
    localparam int NCS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [NCS-1:0] ss_n;

    int total = 0;
    int bad = 0;

    logic       mon_pos = 1'b1;
    logic [7:0] mon_byte = '0;
    time        t_last = 0;
    time        t_prev = 0;

    always #10 clk = ~clk;

    spi_reg_master #(.ADDR_W(7), .NCS(NCS), .DEPTH(16), .HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    always @(posedge sclk) begin
        if (mon_pos) mon_byte = {mon_byte[6:0], mosi};
        t_prev = t_last;
        t_last = $time;
    end
    always @(negedge sclk) if (!mon_pos) mon_byte = {mon_byte[6:0], mosi};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        addr = 7'(a); wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        addr = 7'(a); rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd('h64, s);
            if (s[2]) break;
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd('h60, v); check("R1 control reset", v, 32'h180);
        rd('h64, v); check("R2 status reset", v, 32'h5);
        rd('h70, v); check("R4 select reset", v[NCS-1:0], 4'hF);
        check("R4 ss_n reset", 32'(ss_n), 32'hF);
        check("R10 sclk idle", 32'(sclk), 32'h0);
        rd('h74, v); check("R8 tx occupancy empty", v, 0);
        rd('h78, v); check("R8 rx occupancy empty", v, 0);
        rd('h6C, v); check("R12 empty rx read", v, 0);
    endtask

    task automatic t_select();
        wr('h70, 32'hE);
        #1 check("R4 ss_n follows register", 32'(ss_n), 32'hE);
        wr('h70, 32'hF);
    endtask

    task automatic t_inhibit();
        logic [31:0] v;
        wr('h60, 32'h187);
        wr('h68, 32'h1A5);
        repeat (80) @(posedge clk);
        rd('h64, v); check("R3 inhibit holds byte", v, 32'h1);
        wr('h60, 32'h085);
        repeat (80) @(posedge clk);
        rd('h64, v); check("R3 enable clear holds byte", v, 32'h1);
        wr('h60, 32'h087);
        wait_done();
        rd('h64, v); check("R7 one byte received", v, 32'h4);
        rd('h6C, v); check("R6 low byte only", v, 32'hA5);
    endtask

    task automatic t_loop_ignore();
        logic [31:0] v;
        miso = 1'b0;
        wr('h60, 32'h087);
        wr('h68, 32'h3C);
        wait_done();
        rd('h6C, v); check("R9 loopback returns mosi", v, 32'h3C);
        miso = 1'b1;
        wr('h68, 32'hC3);
        wait_done();
        rd('h6C, v); check("R9 loopback ignores miso", v, 32'hC3);
        wr('h60, 32'h086);
        wr('h68, 32'h3C);
        wait_done();
        rd('h6C, v); check("R9 miso high captured", v, 32'hFF);
        miso = 1'b0;
        wr('h68, 32'h3C);
        wait_done();
        rd('h6C, v); check("R9 miso low captured", v, 32'h00);
    endtask

    task automatic t_modes();
        logic [31:0] v;
        logic [7:0]  b;
        for (int m = 0; m < 8; m++) begin
            logic cp, ch, ls;
            cp = m[0]; ch = m[1]; ls = m[2];
            b  = 8'hB4 ^ 8'(m * 17);
            wr('h60, 32'h087 | (32'(cp) << 3) | (32'(ch) << 4) | (32'(ls) << 9));
            repeat (4) @(posedge clk);
            mon_pos  = (cp == ch);
            mon_byte = '0;
            wr('h68, {24'h0, b});
            wait_done();
            check($sformatf("R11 mosi order mode %0d lsb %0d", {cp, ch}, ls),
                  32'(mon_byte), 32'(ls ? rev8(b) : b));
            rd('h6C, v); check("R10 mode loopback byte", v, 32'(b));
            check("R10 idle level", 32'(sclk), 32'(cp));
            if (m == 0) check("R10 sclk period", 32'(t_last - t_prev), 32'(2 * HALF * 20));
        end
        wr('h60, 32'h087);
    endtask

    task automatic t_full();
        logic [31:0] v;
        wr('h60, 32'h187);
        for (int i = 0; i < 17; i++) wr('h68, 32'(i * 7 + 1));
        rd('h64, v); check("R12 tx full status", v, 32'h9);
        rd('h74, v); check("R8 tx occupancy 16", v, 15);
        wr('h60, 32'h087);
        wait_done();
        rd('h64, v); check("R2 rx full status", v, 32'h6);
        rd('h78, v); check("R8 rx occupancy 16", v, 15);
        for (int i = 0; i < 16; i++) begin
            rd('h6C, v);
            check($sformatf("R12 queued byte %0d", i), v, 32'((i * 7 + 1) & 8'hFF));
        end
        rd('h64, v); check("R12 17th byte dropped", v, 32'h5);
        rd('h6C, v); check("R12 empty read zero", v, 0);
    endtask

    task automatic t_fifo_clear();
        logic [31:0] v;
        wr('h60, 32'h187);
        for (int i = 0; i < 3; i++) wr('h68, 32'h55);
        wr('h60, 32'h1A7);
        rd('h64, v); check("R13 tx clear empties", v, 32'h5);
        rd('h60, v); check("R13 tx clear bit reads 0", v, 32'h187);
        wr('h60, 32'h087);
        wr('h68, 32'h11);
        wr('h68, 32'h22);
        wait_done();
        rd('h64, v); check("R13 rx holds bytes", v, 32'h4);
        wr('h60, 32'h0C7);
        rd('h64, v); check("R13 rx clear empties", v, 32'h5);
        rd('h60, v); check("R13 rx clear bit reads 0", v, 32'h087);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr('h70, 32'h5);
        wr('h60, 32'h28F);
        wr('h40, 32'h0B);
        rd('h70, v); check("R5 wrong key ignored", v[NCS-1:0], 4'h5);
        rd('h60, v); check("R5 wrong key keeps control", v, 32'h28F);
        wr('h40, 32'h0A);
        rd('h60, v); check("R5 control reset by key", v, 32'h180);
        check("R5 ss_n reset by key", 32'(ss_n), 32'hF);
        rd('h64, v); check("R5 status after key", v, 32'h5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_inhibit();
        t_loop_ignore();
        t_modes();
        t_full();
        t_fifo_clear();
        t_soft_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule